// File: doc/BRIEF.md
# Dual Conversion Queue Scan Controller

This block sequences two independent command queues that feed one shared analog-to-digital converter. Each queue has a control register with a scan mode, a write-only arm bit, a write-only software kick bit, an interrupt enable, and a first and a last command index. When an armed queue sees the trigger that belongs to its mode, it waits for the converter. It then walks a command pointer from its first index forward, one step per converter done strobe. The walk ends at its last index, or earlier when the command word being converted carries an end marker. At that point the queue disarms itself, sets a sticky completion flag and, if enabled, raises its interrupt.

The converter itself is outside the block. The block presents `cmd_valid`, `cmd_queue` and `cmd_ptr`. The command memory returns the end marker on `cmd_eoq`, and the converter answers with a one-cycle `conv_done`. A registered `both_idle` output tells clock-control logic when neither queue is in an operating mode. Only then may the converter clock divider be reprogrammed, and only then can result storage be accessed without wait states.

Top module: `cq_scan_ctrl`

## Requirements
- R1: After synchronous reset, `cmd_valid` and `irq` are 0, `both_idle` is 1, and the status register (address 2) reads 0x100.
- R2: Mode codes 0 (off) and 5–7 (reserved) behave identically. An arm write is ignored, and kicks and triggers are ignored. The queue state stays idle and `cmd_valid` stays 0.
- R3: The control register layout is mode [2:0], arm [3], kick [4], interrupt enable [5], first index [8+], last index [16+]. Arm and kick always read 0. Writing arm as 0 leaves an armed queue armed.
- R4: Triggers that arrive before the queue is armed are ignored. Arming works in the same write that selects the scan mode.
- R5: A queue that has been kicked is presented (`cmd_valid`=1) two clock edges after the kick write, with `cmd_ptr` equal to its first index. Each `conv_done` while the queue is presented advances the pointer by one.
- R6: A `conv_done` at the last index, or with `cmd_eoq`=1, ends the scan. `cmd_valid` drops, the queue disarms (state 0), and its done flag sets. Later triggers do not restart it.
- R7: The done flags are status bits 0 and 1 and are cleared by writing 1. `irq[q]` equals done flag AND interrupt enable, one cycle later.
- R8: Each mode has its own trigger. Mode 1 uses the kick bit. Mode 2 uses a rising edge on `ext_trig[q]`, and one edge starts exactly one scan. Mode 4 uses a pulse on `timer_tick[q]`. Mode 3 uses the level of `ext_gate`.
- R9: In mode 3 (queue 0 only), the queue is presented only while `ext_gate` is high. A low gate pauses the queue and holds the pointer, even if `conv_done` arrives. A high gate resumes the queue from the held pointer.
- R10: Queue 1 (second queue) treats mode 3 as off.
- R11: If both queues become ready in the same cycle, queue 0 goes first. Queue 1 waits until queue 0 completes.
- R12: `both_idle` is 1 exactly when both queues hold an off or reserved mode code, one cycle after the write that makes it so. The status register reports queue 0 state in [3:2] and queue 1 state in [5:4], coded 0 idle, 1 armed, 2 waiting, 3 running, and `both_idle` in bit 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 queue 0 control, 1 queue 1 control, 2 status |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | 2 | Read address, same map |
| rd_data | output | DATA_W | Registered read data, one cycle after address |
| ext_trig | input | 2 | Per-queue external edge trigger |
| ext_gate | input | 1 | Gate level for queue 0 gated mode |
| timer_tick | input | 2 | Per-queue periodic timer pulse |
| conv_done | input | 1 | Converter finished the presented command |
| cmd_eoq | input | 1 | Presented command word carries the end marker |
| cmd_valid | output | 1 | A queue is presenting a command |
| cmd_queue | output | 1 | Which queue is presenting |
| cmd_ptr | output | PTR_W | Command index of the running queue |
| irq | output | 2 | Per-queue completion interrupt |
| both_idle | output | 1 | Both queues are in off or reserved modes |

## Verification
The hardest state to reach is a gated scan paused partway through, with a converter done strobe arriving while the gate is low. The bench gets there by arming queue 0 in gated mode, raising the gate, letting one command complete, and then dropping the gate. It then pulses `conv_done` and checks that the pointer has not moved before raising the gate again. Arbitration is reached by arming both queues in timer mode and ticking both timers in the same cycle. This makes both queues ready on one edge, and the bench follows the handover from queue 0 to queue 1.

// File: rtl/cq_pkg.sv
package cq_pkg;
  localparam logic [2:0] MODE_OFF   = 3'd0;
  localparam logic [2:0] MODE_SW    = 3'd1;
  localparam logic [2:0] MODE_EDGE  = 3'd2;
  localparam logic [2:0] MODE_GATE  = 3'd3;
  localparam logic [2:0] MODE_TIMER = 3'd4;

  localparam int ARM_BIT   = 3;
  localparam int KICK_BIT  = 4;
  localparam int IE_BIT    = 5;
  localparam int FIRST_LSB = 8;
  localparam int LAST_LSB  = 16;
  localparam int IDLE_BIT  = 8;

  localparam logic [1:0] ADDR_STAT = 2'd2;

  typedef enum logic [1:0] {Q_IDLE = 2'd0, Q_ARMED = 2'd1, Q_PEND = 2'd2, Q_RUN = 2'd3} qstate_t;

  // Map a raw mode code to the code the queue acts on; reserved codes and
  // unsupported gating collapse to off.
  function automatic logic [2:0] eff_mode(input logic [2:0] raw, input logic gate_ok);
    if (raw > MODE_TIMER) return MODE_OFF;
    if (raw == MODE_GATE && !gate_ok) return MODE_OFF;
    return raw;
  endfunction
endpackage

// File: rtl/cq_trig.sv
module cq_trig
  import cq_pkg::*;
#(
  parameter bit HAS_GATE = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] mode,
  input  logic       kick,
  input  logic       ext,
  input  logic       gate,
  input  logic       tick,
  output logic       fire,
  output logic       gate_ok
);
  logic ext_q;
  logic gate_q;

  always_ff @(posedge clk) begin
    if (rst) ext_q <= 1'b0;
    else     ext_q <= ext;
  end

  if (HAS_GATE) begin : g_gate
    always_ff @(posedge clk) begin
      if (rst) gate_q <= 1'b0;
      else     gate_q <= gate;
    end
  end else begin : g_nogate
    logic unused_gate;
    assign unused_gate = gate;
    assign gate_q = 1'b0;
  end

  always_comb begin
    case (mode)
      MODE_SW:    fire = kick;
      MODE_EDGE:  fire = ext & ~ext_q;
      MODE_GATE:  fire = gate_q;
      MODE_TIMER: fire = tick;
      default:    fire = 1'b0;
    endcase
  end

  assign gate_ok = (mode != MODE_GATE) || gate_q;
endmodule

// File: rtl/cq_seq.sv
module cq_seq
  import cq_pkg::*;
#(
  parameter int PTR_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active,
  input  logic             arm_set,
  input  logic             fire,
  input  logic             grant,
  input  logic             gate_ok,
  input  logic             conv_done,
  input  logic             eoq,
  input  logic [PTR_W-1:0] first,
  input  logic [PTR_W-1:0] last,
  input  logic             clr_done,
  output qstate_t          state,
  output logic [PTR_W-1:0] ptr,
  output logic             done,
  output logic             req,
  output logic             issue
);
  logic step;
  logic at_end;

  assign req    = (state == Q_PEND);
  assign issue  = (state == Q_RUN) && gate_ok;
  assign step   = issue && conv_done;
  assign at_end = (ptr == last) || eoq;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= Q_IDLE;
      ptr   <= '0;
      done  <= 1'b0;
    end else begin
      if (!active && !arm_set) begin
        state <= Q_IDLE;
      end else begin
        case (state)
          Q_IDLE:  if (arm_set) state <= Q_ARMED;
          Q_ARMED: if (fire) state <= Q_PEND;
          Q_PEND:  if (grant) begin
                     state <= Q_RUN;
                     ptr   <= first;
                   end
          Q_RUN:   if (step) begin
                     if (at_end) state <= Q_IDLE;
                     else        ptr   <= ptr + PTR_W'(1);
                   end
          default: state <= Q_IDLE;
        endcase
      end
      if (step && at_end) done <= 1'b1;
      else if (clr_done)  done <= 1'b0;
    end
  end
endmodule

// File: rtl/cq_scan_ctrl.sv
module cq_scan_ctrl
  import cq_pkg::*;
#(
  parameter int PTR_W  = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic [1:0]        ext_trig,
  input  logic              ext_gate,
  input  logic [1:0]        timer_tick,
  input  logic              conv_done,
  input  logic              cmd_eoq,
  output logic              cmd_valid,
  output logic              cmd_queue,
  output logic [PTR_W-1:0]  cmd_ptr,
  output logic [1:0]        irq,
  output logic              both_idle
);
  localparam int NQ = 2;

  logic [NQ-1:0][2:0]       mode_raw;
  logic [NQ-1:0][2:0]       mode_eff;
  logic [NQ-1:0][2:0]       new_eff;
  logic [NQ-1:0]            ie;
  logic [NQ-1:0][PTR_W-1:0] first;
  logic [NQ-1:0][PTR_W-1:0] last;
  logic [NQ-1:0][PTR_W-1:0] q_ptr;
  qstate_t [NQ-1:0]         q_state;
  logic [NQ-1:0] active, arm_set, kick, clr, fire, gate_ok;
  logic [NQ-1:0] grant, req, issue, done, run;
  logic          busy;
  logic          unused_wr;

  assign unused_wr = &{1'b0, wr_data};

  for (genvar q = 0; q < NQ; q++) begin : g_q
    logic wr_ctl;
    assign wr_ctl      = wr_en && (wr_addr == 2'(q));
    assign mode_eff[q] = eff_mode(mode_raw[q], (q == 0));
    assign new_eff[q]  = eff_mode(wr_data[2:0], (q == 0));
    assign active[q]   = (mode_eff[q] != MODE_OFF);
    assign arm_set[q]  = wr_ctl && wr_data[ARM_BIT] && (new_eff[q] != MODE_OFF);
    assign kick[q]     = wr_ctl && wr_data[KICK_BIT];
    assign clr[q]      = wr_en && (wr_addr == ADDR_STAT) && wr_data[q];
    assign run[q]      = (q_state[q] == Q_RUN);

    cq_trig #(.HAS_GATE(q == 0)) u_trig (
      .clk(clk), .rst(rst), .mode(mode_eff[q]), .kick(kick[q]),
      .ext(ext_trig[q]), .gate(ext_gate), .tick(timer_tick[q]),
      .fire(fire[q]), .gate_ok(gate_ok[q])
    );

    cq_seq #(.PTR_W(PTR_W)) u_seq (
      .clk(clk), .rst(rst), .active(active[q]), .arm_set(arm_set[q]),
      .fire(fire[q]), .grant(grant[q]), .gate_ok(gate_ok[q]),
      .conv_done(conv_done), .eoq(cmd_eoq), .first(first[q]), .last(last[q]),
      .clr_done(clr[q]), .state(q_state[q]), .ptr(q_ptr[q]), .done(done[q]),
      .req(req[q]), .issue(issue[q])
    );
  end

  // One converter: a queue owns it from grant until completion.
  assign busy     = |run;
  assign grant[0] = !busy && req[0];
  assign grant[1] = !busy && req[1] && !req[0];

  assign cmd_valid = |issue;
  assign cmd_queue = issue[1];
  assign cmd_ptr   = run[1] ? q_ptr[1] : q_ptr[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_raw  <= '0;
      ie        <= '0;
      first     <= '0;
      last      <= '0;
      irq       <= '0;
      both_idle <= 1'b1;
    end else begin
      for (int q = 0; q < NQ; q++) begin
        if (wr_en && (wr_addr == 2'(q))) begin
          mode_raw[q] <= wr_data[2:0];
          ie[q]       <= wr_data[IE_BIT];
          first[q]    <= wr_data[FIRST_LSB +: PTR_W];
          last[q]     <= wr_data[LAST_LSB +: PTR_W];
        end
      end
      irq       <= done & ie;
      both_idle <= ~|active;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      rd_data <= '0;
      case (rd_addr)
        2'd0, 2'd1: begin
          rd_data[2:0]                  <= mode_raw[rd_addr[0]];
          rd_data[IE_BIT]               <= ie[rd_addr[0]];
          rd_data[FIRST_LSB +: PTR_W]   <= first[rd_addr[0]];
          rd_data[LAST_LSB +: PTR_W]    <= last[rd_addr[0]];
        end
        ADDR_STAT: begin
          rd_data[1:0]     <= done;
          rd_data[3:2]     <= q_state[0];
          rd_data[5:4]     <= q_state[1];
          rd_data[IDLE_BIT] <= both_idle;
        end
        default: rd_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/cq_scan_chk.sv
module cq_scan_chk
  import cq_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       conv_done,
  input logic       cmd_valid,
  input logic       cmd_queue,
  input logic       ext_gate,
  input logic [1:0] rd_addr,
  input logic [1:0] rd_flags,
  input logic [1:0] irq,
  input logic       both_idle,
  input logic [1:0] done,
  input logic       q0_gated,
  input logic [1:0] run
);
  // R11
  single_owner_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(run) <= 1);

  // R9
  gate_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (q0_gated && !$past(ext_gate)) |-> !(cmd_valid && !cmd_queue));

  // R6
  done_cause_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(done[0]) || $rose(done[1])) |-> $past(cmd_valid && conv_done));

  // R7
  irq0_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq[0]) |-> $past(done[0]));

  // R7
  irq1_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq[1]) |-> $past(done[1]));

  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    both_idle |-> !cmd_valid);

  // R3
  arm_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(rd_addr) != ADDR_STAT) |-> (rd_flags == 2'b00));
endmodule

bind cq_scan_ctrl cq_scan_chk u_chk (
  .clk(clk), .rst(rst), .conv_done(conv_done), .cmd_valid(cmd_valid),
  .cmd_queue(cmd_queue), .ext_gate(ext_gate), .rd_addr(rd_addr),
  .rd_flags({rd_data[KICK_BIT], rd_data[ARM_BIT]}), .irq(irq),
  .both_idle(both_idle), .done(done), .q0_gated(mode_eff[0] == MODE_GATE),
  .run(run)
);

// File: tb/tb_cq_scan_ctrl.sv
module tb_cq_scan_ctrl;
  localparam int PTR_W  = 6;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_en = 1'b0;
  logic [1:0]        wr_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [1:0]        rd_addr = '0;
  logic [DATA_W-1:0] rd_data;
  logic [1:0]        ext_trig = '0;
  logic              ext_gate = 1'b0;
  logic [1:0]        timer_tick = '0;
  logic              conv_done = 1'b0;
  logic              cmd_eoq = 1'b0;
  logic              cmd_valid;
  logic              cmd_queue;
  logic [PTR_W-1:0]  cmd_ptr;
  logic [1:0]        irq;
  logic              both_idle;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  cq_scan_ctrl #(.PTR_W(PTR_W), .DATA_W(DATA_W)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .ext_trig(ext_trig), .ext_gate(ext_gate),
    .timer_tick(timer_tick), .conv_done(conv_done), .cmd_eoq(cmd_eoq),
    .cmd_valid(cmd_valid), .cmd_queue(cmd_queue), .cmd_ptr(cmd_ptr),
    .irq(irq), .both_idle(both_idle)
  );

  function automatic logic [31:0] mk(input int mode, input bit arm, input bit kick,
                                     input bit ie, input int first, input int last);
    logic [31:0] w = '0;
    w[2:0]   = 3'(mode);
    w[3]     = arm;
    w[4]     = kick;
    w[5]     = ie;
    w[13:8]  = 6'(first);
    w[21:16] = 6'(last);
    return w;
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic done_pulse(input bit eoq);
    @(negedge clk);
    conv_done = 1'b1; cmd_eoq = eoq;
    @(negedge clk);
    conv_done = 1'b0; cmd_eoq = 1'b0;
  endtask

  task automatic poll_valid(input int max, output bit ok);
    ok = 1'b0;
    for (int i = 0; i < max; i++) begin
      if (cmd_valid) begin ok = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1", "cmd_valid", 32'(cmd_valid), 0);
    chk("R1", "irq", 32'(irq), 0);
    chk("R1", "both_idle", 32'(both_idle), 1);
    rd(2'd2, v);
    chk("R1", "status", v, 32'h100);
  endtask

  task automatic t_disabled();
    logic [31:0] v;
    wr(2'd0, mk(0, 1, 0, 0, 0, 3));
    rd(2'd2, v);
    chk("R2", "arm ignored in off mode", v, 32'h100);
    wr(2'd0, mk(6, 1, 0, 0, 0, 3));
    rd(2'd2, v);
    chk("R2", "arm ignored in reserved mode", v, 32'h100);
    wr(2'd0, mk(6, 0, 1, 0, 0, 3));
    step(3);
    chk("R2", "kick ignored in reserved mode", 32'(cmd_valid), 0);
    wr(2'd0, mk(0, 0, 0, 0, 0, 0));
  endtask

  task automatic t_software();
    logic [31:0] v;
    wr(2'd0, mk(1, 0, 1, 1, 2, 4));
    step(3);
    chk("R4", "kick before arm ignored", 32'(cmd_valid), 0);
    chk("R12", "both_idle low with queue0 in mode 1", 32'(both_idle), 0);
    wr(2'd0, mk(1, 1, 0, 1, 2, 4));
    rd(2'd0, v);
    chk("R3", "ctrl readback hides arm", v, 32'h0004_0221);
    rd(2'd2, v);
    chk("R4", "armed state", v, 32'h4);
    wr(2'd0, mk(1, 0, 0, 1, 2, 4));
    rd(2'd2, v);
    chk("R3", "arm write of 0 keeps armed", v, 32'h4);
    wr(2'd0, mk(1, 0, 1, 1, 2, 4));
    chk("R5", "not yet presented", 32'(cmd_valid), 0);
    step(1);
    chk("R5", "presented", 32'(cmd_valid), 1);
    chk("R5", "first index", 32'(cmd_ptr), 2);
    chk("R5", "queue", 32'(cmd_queue), 0);
    done_pulse(1'b0);
    chk("R5", "ptr step 1", 32'(cmd_ptr), 3);
    done_pulse(1'b0);
    chk("R5", "ptr step 2", 32'(cmd_ptr), 4);
    done_pulse(1'b0);
    chk("R6", "ended at last", 32'(cmd_valid), 0);
    chk("R7", "irq not yet", 32'(irq), 0);
    step(1);
    chk("R7", "irq raised", 32'(irq), 1);
    rd(2'd2, v);
    chk("R6", "done flag, disarmed", v, 32'h1);
    wr(2'd0, mk(1, 0, 1, 1, 2, 4));
    step(3);
    chk("R6", "no restart after completion", 32'(cmd_valid), 0);
    wr(2'd2, 32'h1);
    step(1);
    chk("R7", "irq cleared", 32'(irq), 0);
    rd(2'd2, v);
    chk("R7", "done flag cleared", v[1:0], 0);
    wr(2'd0, mk(0, 0, 0, 0, 0, 0));
  endtask

  task automatic t_edge_eoq();
    logic [31:0] v;
    bit ok;
    wr(2'd1, mk(2, 1, 0, 0, 0, 9));
    ext_trig[1] = 1'b1;
    poll_valid(8, ok);
    chk("R8", "edge trigger starts queue1", 32'(ok), 1);
    chk("R8", "queue id", 32'(cmd_queue), 1);
    chk("R8", "queue1 first", 32'(cmd_ptr), 0);
    done_pulse(1'b0);
    chk("R5", "queue1 step", 32'(cmd_ptr), 1);
    done_pulse(1'b1);
    chk("R6", "end marker stops", 32'(cmd_valid), 0);
    step(1);
    chk("R7", "irq off when disabled", 32'(irq), 0);
    rd(2'd2, v);
    chk("R6", "queue1 done flag", v, 32'h2);
    step(3);
    chk("R8", "held level gives one scan", 32'(cmd_valid), 0);
    ext_trig[1] = 1'b0;
    wr(2'd2, 32'h2);
    wr(2'd1, mk(0, 0, 0, 0, 0, 0));
  endtask

  task automatic t_gate();
    bit ok;
    wr(2'd0, mk(3, 1, 0, 0, 5, 7));
    ext_gate = 1'b1;
    poll_valid(8, ok);
    chk("R8", "gate level starts queue0", 32'(ok), 1);
    chk("R9", "gated first", 32'(cmd_ptr), 5);
    done_pulse(1'b0);
    chk("R9", "gated step", 32'(cmd_ptr), 6);
    ext_gate = 1'b0;
    step(1);
    chk("R9", "paused", 32'(cmd_valid), 0);
    done_pulse(1'b0);
    chk("R9", "pointer held while paused", 32'(cmd_ptr), 6);
    chk("R9", "still paused", 32'(cmd_valid), 0);
    ext_gate = 1'b1;
    step(1);
    chk("R9", "resumed", 32'(cmd_valid), 1);
    chk("R9", "resume pointer", 32'(cmd_ptr), 6);
    done_pulse(1'b0);
    done_pulse(1'b0);
    chk("R9", "gated scan complete", 32'(cmd_valid), 0);
    ext_gate = 1'b0;
    wr(2'd2, 32'h1);
    wr(2'd0, mk(0, 0, 0, 0, 0, 0));
  endtask

  task automatic t_q1_gate();
    logic [31:0] v;
    wr(2'd1, mk(3, 1, 0, 0, 0, 2));
    ext_gate = 1'b1;
    step(4);
    chk("R10", "queue1 gated never runs", 32'(cmd_valid), 0);
    rd(2'd2, v);
    chk("R10", "queue1 idle, both idle", v, 32'h100);
    ext_gate = 1'b0;
    wr(2'd1, mk(0, 0, 0, 0, 0, 0));
  endtask

  task automatic t_priority();
    bit ok;
    wr(2'd0, mk(4, 1, 0, 0, 1, 1));
    wr(2'd1, mk(4, 1, 0, 0, 3, 3));
    @(negedge clk);
    timer_tick = 2'b11;
    @(negedge clk);
    timer_tick = 2'b00;
    poll_valid(8, ok);
    chk("R8", "timer tick starts", 32'(ok), 1);
    chk("R11", "queue0 first", 32'(cmd_queue), 0);
    chk("R11", "queue0 ptr", 32'(cmd_ptr), 1);
    step(2);
    chk("R11", "queue1 still waiting", 32'(cmd_queue), 0);
    done_pulse(1'b0);
    chk("R11", "gap after queue0", 32'(cmd_valid), 0);
    step(1);
    chk("R11", "queue1 granted", 32'(cmd_valid), 1);
    chk("R11", "queue1 id", 32'(cmd_queue), 1);
    chk("R11", "queue1 ptr", 32'(cmd_ptr), 3);
    done_pulse(1'b0);
    chk("R6", "queue1 done", 32'(cmd_valid), 0);
    wr(2'd0, mk(0, 0, 0, 0, 0, 0));
    step(1);
    chk("R12", "one queue still in mode", 32'(both_idle), 0);
    wr(2'd1, mk(7, 0, 0, 0, 0, 0));
    chk("R12", "not yet idle", 32'(both_idle), 0);
    step(1);
    chk("R12", "both idle", 32'(both_idle), 1);
    wr(2'd2, 32'h3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_disabled();
    t_software();
    t_edge_eoq();
    t_gate();
    t_q1_gate();
    t_priority();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule